// File: doc/BRIEF.md
# Serial Audio Port Error and Frame-Status Flags

This block keeps the sticky error flags and the frame-sync status flag of a time-slotted synchronous serial audio port. Slot timing comes from the port's sequencer. Buffer state comes from the data path. Register-access strobes come from the bus decoder. From these inputs the block keeps a transmit-underrun flag, a receive-overrun flag and a transmit-frame-sync flag.

An error flag does not raise an interrupt of its own. While a flag is set, it moves the matching transmit or receive interrupt request to a "with exception" vector. When a transmit slot finds no fresh word, the block tells the transmitter in that same cycle to send the previous word again.

Each error flag is cleared by a two-step software sequence. First, a status read must see the flag set, which arms the flag. Then, in a later cycle, a specific data access clears it. A new error event that arrives before the clearing access disarms the flag, so the error is not lost. No data stream passes through this block, so every pin is a plain level or single-cycle strobe with no valid/ready handshake.

Top module: `sport_err_flags`

## Requirements
- R1: With `port_en` high, a transmit slot event that finds `tx_empty` high sets `unr_flag` from the next cycle. In network mode (`net_mode`=1) every `slot_tx` pulse is a transmit slot event. In normal mode (`net_mode`=0) only a `slot_tx` pulse together with `frm_first` is one.
- R2: `tx_repeat` is high in the same cycle as an underrun event (port enabled, transmit slot event, `tx_empty` high), and low in every other cycle.
- R3: In normal mode, a `slot_tx` pulse without `frm_first` neither sets `unr_flag` nor raises `tx_repeat`.
- R4: `unr_flag` clears one cycle after `tx_data_wr` or `tx_spec_wr`, provided a `st_rd` in an earlier cycle saw `unr_flag` set. A write with no such earlier read leaves the flag set.
- R5: With `port_en` and `rx_en` high, `slot_rx` together with `rx_ovr_det` sets `ovr_flag` from the next cycle. The flag clears one cycle after `rx_data_rd`, provided a `st_rd` in an earlier cycle saw it set.
- R6: Dropping `rx_en` does not change `ovr_flag`.
- R7: While `port_en` is low, all three flags are cleared at the next edge, any armed state is dropped, and no event sets a flag.
- R8: In network mode, a `slot_tx` pulse with `frm_first` sets `tfs_flag`, and a `slot_tx` pulse without `frm_first` clears it. In normal mode `tfs_flag` is cleared.
- R9: `rx_vec` is 2'b00 while `ovr_flag` is clear and 2'b01 while it is set. `tx_vec` is 2'b10 while `unr_flag` is clear and 2'b11 while it is set.
- R10: If a flag's error event repeats after the arming status read but before the clearing access, the clearing access leaves the flag set.
- R11: When an error event and the clearing access fall in the same cycle, the flag stays set.
- R12: After reset all flags are clear, `tx_repeat` is low, `rx_vec`=2'b00 and `tx_vec`=2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_en | input | 1 | Port enable; low clears all flags |
| rx_en | input | 1 | Receiver enable; gates overrun detection |
| net_mode | input | 1 | 1 = network (multi-slot) mode, 0 = normal mode |
| slot_tx | input | 1 | Transmit slot start strobe |
| slot_rx | input | 1 | Receive slot start strobe |
| frm_first | input | 1 | Current slot is the first of the frame (frame sync) |
| tx_empty | input | 1 | No new transmit word pending |
| rx_ovr_det | input | 1 | Receive buffer still full at slot start |
| st_rd | input | 1 | Status register read strobe |
| tx_data_wr | input | 1 | Transmit data register write strobe |
| tx_spec_wr | input | 1 | Transmit special (slot-skip) register write strobe |
| rx_data_rd | input | 1 | Receive data register read strobe |
| unr_flag | output | 1 | Sticky transmit underrun |
| ovr_flag | output | 1 | Sticky receive overrun |
| tfs_flag | output | 1 | First slot of frame in transmission (network mode) |
| tx_repeat | output | 1 | Resend previous word in this slot |
| tx_vec | output | 2 | Transmit interrupt vector code |
| rx_vec | output | 2 | Receive interrupt vector code |

## Verification
The hardest case to reach is the disarming race. The arming status read, a repeat of the error event and the clearing access must come in that order, in separate cycles, with the port enabled throughout. Random strobes seldom line these up. Directed sequences build the race on purpose, and also the same-cycle set/clear collision. Around them, biased random cycles fire status reads and data accesses often enough that natural arm-then-clear pairs occur many times for both flags.

// File: rtl/sport_flag_pkg.sv
package sport_flag_pkg;
  typedef enum logic {
    MODE_NORMAL  = 1'b0,
    MODE_NETWORK = 1'b1
  } slot_mode_e;

  localparam int VEC_W = 2;
  localparam logic [VEC_W-1:0] VEC_RX     = 2'b00;
  localparam logic [VEC_W-1:0] VEC_RX_EXC = 2'b01;
  localparam logic [VEC_W-1:0] VEC_TX     = 2'b10;
  localparam logic [VEC_W-1:0] VEC_TX_EXC = 2'b11;

  localparam int NUM_ERR = 2;
  localparam int ERR_UNR = 0;
  localparam int ERR_OVR = 1;
endpackage

// File: rtl/sticky_err_cell.sv
module sticky_err_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic set_i,
  input  logic rd_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, arm_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !en_i) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else if (set_i) begin
      flag_q <= 1'b1;          // new event wins and disarms
      arm_q  <= 1'b0;
    end else if (arm_q && clr_i) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else if (rd_i && flag_q) begin
      arm_q  <= 1'b1;
    end
  end

  assign flag_o = flag_q;

  // R1
  set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && set_i) |=> flag_q);
  // R7
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !flag_q);
  // R4
  clear_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(!en_i || (arm_q && clr_i)));
endmodule

// File: rtl/tfs_tracker.sv
module tfs_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic net_i,
  input  logic slot_i,
  input  logic first_i,
  output logic tfs_o
);
  logic tfs_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !en_i)    tfs_q <= 1'b0;
    else if (!net_i)        tfs_q <= 1'b0;
    else if (slot_i)        tfs_q <= first_i;
  end

  assign tfs_o = tfs_q;

  // R8
  tfs_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && net_i && slot_i) |=> (tfs_q == $past(first_i)));
endmodule

// File: rtl/vec_sel.sv
module vec_sel
  import sport_flag_pkg::*;
(
  input  logic             unr_i,
  input  logic             ovr_i,
  output logic [VEC_W-1:0] tx_vec_o,
  output logic [VEC_W-1:0] rx_vec_o
);
  always_comb begin
    tx_vec_o = unr_i ? VEC_TX_EXC : VEC_TX;
    rx_vec_o = ovr_i ? VEC_RX_EXC : VEC_RX;
  end
endmodule

// File: rtl/sport_err_flags.sv
module sport_err_flags
  import sport_flag_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             port_en,
  input  logic             rx_en,
  input  logic             net_mode,
  input  logic             slot_tx,
  input  logic             slot_rx,
  input  logic             frm_first,
  input  logic             tx_empty,
  input  logic             rx_ovr_det,
  input  logic             st_rd,
  input  logic             tx_data_wr,
  input  logic             tx_spec_wr,
  input  logic             rx_data_rd,
  output logic             unr_flag,
  output logic             ovr_flag,
  output logic             tfs_flag,
  output logic             tx_repeat,
  output logic [VEC_W-1:0] tx_vec,
  output logic [VEC_W-1:0] rx_vec
);
  slot_mode_e mode;
  logic tx_slot_ev;
  logic [NUM_ERR-1:0] err_set, err_clr, err_flag;

  assign mode       = slot_mode_e'(net_mode);
  assign tx_slot_ev = slot_tx && (mode == MODE_NETWORK || frm_first);

  always_comb begin
    err_set          = '0;
    err_clr          = '0;
    err_set[ERR_UNR] = tx_slot_ev && tx_empty;
    err_clr[ERR_UNR] = tx_data_wr || tx_spec_wr;
    err_set[ERR_OVR] = rx_en && slot_rx && rx_ovr_det;
    err_clr[ERR_OVR] = rx_data_rd;
  end

  for (genvar g = 0; g < NUM_ERR; g++) begin : g_err
    sticky_err_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (port_en),
      .set_i  (err_set[g]),
      .rd_i   (st_rd),
      .clr_i  (err_clr[g]),
      .flag_o (err_flag[g])
    );
  end

  assign unr_flag  = err_flag[ERR_UNR];
  assign ovr_flag  = err_flag[ERR_OVR];
  assign tx_repeat = port_en && err_set[ERR_UNR];

  tfs_tracker u_tfs (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (port_en),
    .net_i   (net_mode),
    .slot_i  (slot_tx),
    .first_i (frm_first),
    .tfs_o   (tfs_flag)
  );

  vec_sel u_vec (
    .unr_i    (unr_flag),
    .ovr_i    (ovr_flag),
    .tx_vec_o (tx_vec),
    .rx_vec_o (rx_vec)
  );

  // R2
  repeat_marks_unr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_repeat |=> unr_flag);
  // R6
  rxen_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && ovr_flag && !rx_data_rd) |=> ovr_flag);
  // R3
  normal_no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!net_mode && !frm_first) |-> !tx_repeat);
endmodule

// File: tb/tb_sport_err_flags.sv
module tb_sport_err_flags;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic port_en = 0, rx_en = 0, net_mode = 0, slot_tx = 0, slot_rx = 0;
  logic frm_first = 0, tx_empty = 0, rx_ovr_det = 0;
  logic st_rd = 0, tx_data_wr = 0, tx_spec_wr = 0, rx_data_rd = 0;
  logic unr_flag, ovr_flag, tfs_flag, tx_repeat;
  logic [1:0] tx_vec, rx_vec;

  int tests = 0, fails = 0;
  logic m_unr = 0, m_ovr = 0, m_tfs = 0, m_arm_u = 0, m_arm_o = 0;

  always #4 clk = ~clk;

  sport_err_flags dut (.*);

  function automatic logic [1:0] exp_tx_vec(logic u); return u ? 2'b11 : 2'b10; endfunction
  function automatic logic [1:0] exp_rx_vec(logic o); return o ? 2'b01 : 2'b00; endfunction
  function automatic logic exp_unr_ev();
    return port_en && slot_tx && (net_mode || frm_first) && tx_empty;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    slot_tx = 0; slot_rx = 0; frm_first = 0; tx_empty = 0; rx_ovr_det = 0;
    st_rd = 0; tx_data_wr = 0; tx_spec_wr = 0; rx_data_rd = 0;
  endtask

  task automatic cyc(string tag);
    logic u_ev, o_ev;
    #1;
    chk({tag, " R2 tx_repeat"}, {7'd0, tx_repeat}, {7'd0, exp_unr_ev()});
    u_ev = exp_unr_ev();
    o_ev = rx_en && slot_rx && rx_ovr_det;
    @(posedge clk);
    if (!port_en) begin
      m_unr = 0; m_ovr = 0; m_tfs = 0; m_arm_u = 0; m_arm_o = 0;
    end else begin
      if (u_ev) begin m_unr = 1; m_arm_u = 0; end
      else if (m_arm_u && (tx_data_wr || tx_spec_wr)) begin m_unr = 0; m_arm_u = 0; end
      else if (st_rd && m_unr) m_arm_u = 1;
      if (o_ev) begin m_ovr = 1; m_arm_o = 0; end
      else if (m_arm_o && rx_data_rd) begin m_ovr = 0; m_arm_o = 0; end
      else if (st_rd && m_ovr) m_arm_o = 1;
      if (!net_mode) m_tfs = 0;
      else if (slot_tx) m_tfs = frm_first;
    end
    @(negedge clk);
    chk({tag, " unr_flag"}, {7'd0, unr_flag}, {7'd0, m_unr});
    chk({tag, " ovr_flag"}, {7'd0, ovr_flag}, {7'd0, m_ovr});
    chk({tag, " R8 tfs_flag"}, {7'd0, tfs_flag}, {7'd0, m_tfs});
    chk({tag, " R9 vectors"}, {4'd0, tx_vec, rx_vec}, {4'd0, exp_tx_vec(m_unr), exp_rx_vec(m_ovr)});
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12 reset state
    chk("R12 reset flags", {5'd0, unr_flag, ovr_flag, tfs_flag}, 8'd0);
    chk("R12 reset vectors", {4'd0, tx_vec, rx_vec}, 8'b0000_1000);
    chk("R12 reset repeat", {7'd0, tx_repeat}, 8'd0);
    port_en = 1; rx_en = 1; net_mode = 1;
    cyc("R12 idle");
    // R1 R2 R9: network-mode underrun
    slot_tx = 1; tx_empty = 1; cyc("R1 underrun net"); idle();
    // R4: write without arming keeps flag
    tx_data_wr = 1; cyc("R4 unarmed write"); idle();
    st_rd = 1; cyc("R4 arm read"); idle();
    tx_spec_wr = 1; cyc("R4 special write clears"); idle();
    // R3: normal mode, no frame sync
    net_mode = 0; slot_tx = 1; tx_empty = 1; cyc("R3 normal no sync"); idle();
    slot_tx = 1; tx_empty = 1; frm_first = 1; cyc("R1 normal with sync"); idle();
    // R10: repeat event between arm and clear
    st_rd = 1; cyc("R10 arm"); idle();
    slot_tx = 1; tx_empty = 1; frm_first = 1; cyc("R10 re-set"); idle();
    tx_data_wr = 1; cyc("R10 write keeps"); idle();
    // R11: same-cycle set and clear
    st_rd = 1; cyc("R11 arm"); idle();
    slot_tx = 1; tx_empty = 1; frm_first = 1; tx_data_wr = 1; cyc("R11 collide"); idle();
    // R5: overrun set, arm, clear
    slot_rx = 1; rx_ovr_det = 1; cyc("R5 overrun set"); idle();
    rx_data_rd = 1; cyc("R5 unarmed read"); idle();
    // R6: receiver disable keeps overrun
    rx_en = 0; cyc("R6 rx off"); cyc("R6 rx off 2");
    slot_rx = 1; rx_ovr_det = 1; cyc("R6 rx off event"); idle();
    rx_en = 1;
    st_rd = 1; cyc("R5 arm"); idle();
    rx_data_rd = 1; cyc("R5 read clears"); idle();
    // R8: frame-sync flag in network mode
    net_mode = 1; slot_tx = 1; frm_first = 1; cyc("R8 first slot"); idle();
    cyc("R8 hold");
    slot_tx = 1; cyc("R8 next slot"); idle();
    slot_tx = 1; frm_first = 1; cyc("R8 first again"); idle();
    net_mode = 0; cyc("R8 normal clears"); net_mode = 1;
    // R7: disable clears everything and blocks events
    slot_tx = 1; tx_empty = 1; frm_first = 1; slot_rx = 1; rx_ovr_det = 1; cyc("R7 set all"); idle();
    port_en = 0; cyc("R7 disable");
    slot_tx = 1; tx_empty = 1; slot_rx = 1; rx_ovr_det = 1; cyc("R7 events ignored"); idle();
    port_en = 1; cyc("R7 re-enable");
    // random phase
    for (int i = 0; i < 3000; i++) begin
      port_en    = ($urandom % 40) != 0;
      rx_en      = ($urandom % 8) != 0;
      net_mode   = ($urandom % 3) != 0;
      slot_tx    = ($urandom % 3) == 0;
      slot_rx    = ($urandom % 3) == 0;
      frm_first  = ($urandom % 3) == 0;
      tx_empty   = ($urandom % 4) == 0;
      rx_ovr_det = ($urandom % 4) == 0;
      st_rd      = ($urandom % 3) == 0;
      tx_data_wr = ($urandom % 4) == 0;
      tx_spec_wr = ($urandom % 8) == 0;
      rx_data_rd = ($urandom % 4) == 0;
      cyc("R1 R4 R5 R10 R11 random");
    end
    idle();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule